// File: doc/BRIEF.md
# Reloadable Count-Down Interval Timer

This block is a 16-bit down-counter paired with a separate 16-bit reload latch. A byte-wide register port with four selects reaches both of them. Software writes the two latch bytes. One of the two high-byte selects also copies the whole latch into the counter and arms the timer. Reads return the live counter bytes or the stored latch bytes, depending on the select.

The counter steps down by one on each cycle in which the count enable `tick` is high. When it is already zero, the next enabled cycle is a time-out: the counter reloads from the latch, and the time-out flag may be raised. In one-shot mode the flag is raised only at the first time-out after a load. In continuous mode it is raised at every time-out, and the `wave_out` pin toggles, which gives a square wave whose half-period is the latch value plus one enabled cycle. The flag clears as a side effect of the bus access itself, in the same edge as the strobe.

Top module: `ivtimer`

## Requirements
- R1: After a synchronous reset, the counter, the latch, the flag, `wave_out` and `rdata` are all zero, and the timer is not armed.
- R2: A write at select 1 stores `wdata` as the latch high byte. At the same edge it loads the counter with {wdata, latch low byte} and arms the timer.
- R3: A write at select 0 or select 2 changes only the latch low byte. A write at select 3 changes only the latch high byte. None of these three writes alters the counter.
- R4: A read strobe at select 0 or 1 returns the counter low or high byte. Select 2 or 3 returns the latch low or high byte. The value sampled at the strobe edge appears on `rdata` one cycle after the strobe and holds until the next read.
- R5: With `tick` high and the counter non-zero, the counter decreases by exactly one per clock.
- R6: With `tick` high and the counter at zero, the counter reloads from the latch. This is a time-out. In continuous mode (`cont_mode`=1), a time-out sets the flag.
- R7: Any write clears the flag, and so does a read at select 0 or 1. A read at select 2 or 3 leaves the flag unchanged.
- R8: In one-shot mode (`cont_mode`=0), only the first time-out after a select-1 load sets the flag. Later time-outs reload the counter but leave the flag unchanged.
- R9: In continuous mode, `wave_out` toggles at every time-out. In one-shot mode it does not change.
- R10: When a select-1 write and an enabled tick fall in the same cycle, the load wins and the counter takes the written value.
- R11: When a time-out that sets the flag coincides with a clearing access, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| cont_mode | input | 1 | 1 = continuous reload with flag each time-out, 0 = one-shot |
| sel | input | 2 | Register select 0..3 |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| flag | output | 1 | Time-out flag |
| wave_out | output | 1 | Square-wave output, continuous mode |

## Verification
Counter loads, latch updates, flag changes and `wave_out` toggles all land on the same edge that samples the strobe or the tick. The bench drives its inputs after a falling edge and checks these outputs just after the next falling edge. Read data is due one cycle after the strobe. The driver queues the expected byte when it raises `rd`, and the monitor pops it one full cycle later. Every read is done with `tick` low, so the counter value it returns is exact. The priority cases (R10, R11) place the strobe and the tick in the same cycle on purpose.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO  = 2'd0,
    SEL_HI_LOAD = 2'd1,
    SEL_LAT_LO  = 2'd2,
    SEL_LAT_HI  = 2'd3
  } ivt_sel_e;
endpackage

// File: rtl/ivt_latch.sv
module ivt_latch #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [1:0]          sel,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] latch_q
);
  // Select bit 0 picks the byte: 0/2 low, 1/3 high.
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (wr) begin
      if (sel[0]) latch_q[2*BYTE_W-1:BYTE_W] <= wdata;
      else        latch_q[BYTE_W-1:0]        <= wdata;
    end
  end
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             timeout
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign timeout = tick && at_zero && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (tick) begin
      if (at_zero) begin
        cnt_q   <= reload_val;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivt_status.sv
module ivt_status (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic cont_mode,
  input  logic armed,
  input  logic clr,
  output logic flag_q,
  output logic wave_q
);
  logic raise;
  assign raise = timeout && (cont_mode || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (raise)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (timeout && cont_mode) wave_q <= ~wave_q;
    end
  end
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  logic [1:0]          sel,
  input  logic [2*BYTE_W-1:0] cnt,
  input  logic [2*BYTE_W-1:0] latch,
  output logic [BYTE_W-1:0]   rdata_q
);
  logic [2*BYTE_W-1:0] src;
  assign src = sel[1] ? latch : cnt;

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel[0] ? src[2*BYTE_W-1:BYTE_W] : src[BYTE_W-1:0];
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cont_mode,
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              flag,
  output logic              wave_out
);
  import ivt_pkg::*;
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] latch_q, cnt_q;
  logic             load, armed_q, timeout, clr;

  assign load = wr && (ivt_sel_e'(sel) == SEL_HI_LOAD);
  assign clr  = wr || (rd && !sel[1]);

  ivt_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst(rst), .wr(wr), .sel(sel), .wdata(wdata), .latch_q(latch_q)
  );

  ivt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .load_val({wdata, latch_q[BYTE_W-1:0]}), .reload_val(latch_q),
    .cnt_q(cnt_q), .armed_q(armed_q), .timeout(timeout)
  );

  ivt_status u_status (
    .clk(clk), .rst(rst), .timeout(timeout), .cont_mode(cont_mode),
    .armed(armed_q), .clr(clr), .flag_q(flag), .wave_q(wave_out)
  );

  ivt_rdmux #(.BYTE_W(BYTE_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd(rd), .sel(sel), .cnt(cnt_q), .latch(latch_q),
    .rdata_q(rdata)
  );
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                cont_mode,
  input logic [1:0]          sel,
  input logic                wr,
  input logic                rd,
  input logic [BYTE_W-1:0]   wdata,
  input logic                flag,
  input logic                wave_out,
  input logic                timeout,
  input logic [2*BYTE_W-1:0] cnt_q,
  input logic [2*BYTE_W-1:0] latch_q
);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd1) |=> cnt_q == {$past(wdata), $past(latch_q[BYTE_W-1:0])});
  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != '0 && !(wr && sel == 2'd1)) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !(wr && sel == 2'd1)) |=> cnt_q == $past(latch_q));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr || (rd && !sel[1])) && !timeout) |=> !flag);
  // R9
  wave_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && cont_mode) |=> wave_out != $past(wave_out));
  // R9
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(timeout && cont_mode) |=> $stable(wave_out));
  // R11
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && cont_mode) |=> flag);
endmodule

bind ivtimer ivtimer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cont_mode(cont_mode), .sel(sel),
  .wr(wr), .rd(rd), .wdata(wdata), .flag(flag), .wave_out(wave_out),
  .timeout(timeout), .cnt_q(cnt_q), .latch_q(latch_q)
);

// File: tb/tb_ivtimer.sv
`timescale 1ns/1ps
module tb_ivtimer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, cont_mode = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       flag, wave_out;

  int vectors = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       take = 1'b0;

  always #5 clk = ~clk;

  ivtimer dut (
    .clk(clk), .rst(rst), .tick(tick), .cont_mode(cont_mode), .sel(sel),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .flag(flag), .wave_out(wave_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: read data is due one cycle after the strobe.
  always @(posedge clk) take <= rd;
  always @(negedge clk) begin
    #1;
    if (take && exp_q.size() > 0) chk(tag_q.pop_front(), {8'd0, rdata}, {8'd0, exp_q.pop_front()});
  end

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d; tick = tk;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, input logic [7:0] e, input string tag,
                        input logic tk = 1'b0);
    @(negedge clk); rd = 1'b1; sel = s; tick = tk;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0; tick = 1'b0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R1 rdata", {8'd0, rdata}, 16'd0);
    chk("R1 flag", {15'd0, flag}, 16'd0);
    chk("R1 wave", {15'd0, wave_out}, 16'd0);
    rd_reg(2'd0, 8'h00, "R1 counter lo");
    rd_reg(2'd3, 8'h00, "R1 latch hi");
    // R1: not armed -> a time-out at zero does not raise the flag in one-shot mode
    tick_n(1); #2;
    chk("R1 not armed", {15'd0, flag}, 16'd0);

    // R3: latch-only writes
    wr_reg(2'd0, 8'h05);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd2, 8'h05, "R3 latch lo");
    rd_reg(2'd3, 8'h00, "R3 latch hi");
    rd_reg(2'd0, 8'h00, "R3 counter untouched");

    // R2 + R4: load write
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd0, 8'h05, "R2 counter lo");
    rd_reg(2'd1, 8'h01, "R2/R4 counter hi");
    rd_reg(2'd3, 8'h01, "R4 latch hi");
    #2; chk("R4 rdata holds", {8'd0, rdata}, 16'h0001);

    // R5: decrement
    tick_n(3);
    rd_reg(2'd0, 8'h02, "R5 counter lo after 3 ticks");

    // R6/R8: one-shot
    wr_reg(2'd0, 8'h03);
    wr_reg(2'd1, 8'h00);
    tick_n(3); #2;
    chk("R6 no flag before zero passes", {15'd0, flag}, 16'd0);
    tick_n(1); #2;
    chk("R6 flag on time-out", {15'd0, flag}, 16'd1);
    rd_reg(2'd2, 8'h03, "R7 latch read");
    #2; chk("R7 latch read keeps flag", {15'd0, flag}, 16'd1);
    rd_reg(2'd0, 8'h03, "R6 reloaded value");
    #2; chk("R7 counter read clears flag", {15'd0, flag}, 16'd0);
    tick_n(4); #2;
    chk("R8 second one-shot time-out", {15'd0, flag}, 16'd0);
    chk("R9 no wave in one-shot", {15'd0, wave_out}, 16'd0);

    // R9: continuous
    cont_mode = 1'b1;
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd1, 8'h00);
    tick_n(3); #2;
    chk("R6 continuous flag", {15'd0, flag}, 16'd1);
    chk("R9 wave toggles high", {15'd0, wave_out}, 16'd1);
    tick_n(3); #2;
    chk("R9 wave toggles low", {15'd0, wave_out}, 16'd0);
    rd_reg(2'd0, 8'h02, "R6 continuous reload");
    tick_n(3); #2;
    chk("R9 wave high again", {15'd0, wave_out}, 16'd1);
    chk("R6 flag again", {15'd0, flag}, 16'd1);
    wr_reg(2'd2, 8'h02);
    #2; chk("R7 write clears flag", {15'd0, flag}, 16'd0);

    // R10: load beats tick
    wr_reg(2'd0, 8'h10);
    wr_reg(2'd1, 8'h00, 1'b1);
    rd_reg(2'd0, 8'h10, "R10 load wins");

    // R11: set beats clear
    wr_reg(2'd0, 8'h01);
    wr_reg(2'd1, 8'h00);
    tick_n(1);
    rd_reg(2'd1, 8'h00, "R11 read during time-out", 1'b1);
    #2; chk("R11 flag set wins", {15'd0, flag}, 16'd1);
    rd_reg(2'd0, 8'h01, "R11 reload after time-out");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule